// File: doc/BRIEF.md
# BCD Real-Time Clock Calendar

This block keeps the time of day and a calendar spanning two centuries. All fields are stored as packed BCD digits, and the block advances once per pulse on a one-second tick input. The oscillator and the divider that produce this tick sit outside the block. The calendar fields are the century, year, month, date and a day-of-week counter. The hour is always stored internally on a 24-hour scale. A mode bit chooses whether software sees and writes the hour as 24-hour or as 12-hour with an AM/PM bit.

Software loads values through a single 32-bit write port. A 2-bit selector picks one of four targets: time, calendar, alarm or control. Every time, calendar and alarm write is validated as a whole before it is accepted. The checks cover digit legality, field ranges, reserved bits and date feasibility for the written month, year and century. A refused write changes no register and raises a sticky entry-error flag. An alarm compares enabled fields against the running clock. A periodic event fires on each second, minute, hour, day, week or month boundary. Both events set sticky flags, and those flags drive the interrupt output.

Top module: `rtc_calendar`

## Requirements
- R1: After reset the time is 00:00:00 in 24-hour mode. The date is year 00 of the first century (parameter, default 19), month 01, date 01, day-of-week 1. The alarm is disabled, the periodic select is off and all flags are clear. Every stored digit is a BCD value of 0 to 9.
- R2: On a `tick_1hz` pulse, seconds advance. Seconds wrap 59→00 and carry into minutes, minutes wrap 59→00 into hours, and hours wrap 23→00 into the date. `time_o` holds seconds in [6:0], minutes in [14:8], hour in [21:16] and the PM bit in [22]; all other bits read 0.
- R3: The date wraps after the last day of its month. April, June, September and November have 30 days, and the other months have 31 except February. February has 29 days when the year is divisible by 4, except year 00 of a century not divisible by 4. Month 12 wraps to 01 and carries into the year. Year 99 carries into the century, and the second century wraps back to the first. `cal_o` holds century [7:0], year [15:8], month [20:16], day-of-week [23:21] and date [29:24].
- R4: Setting control bit 0 selects 12-hour mode. In 12-hour mode the hour reads 12, 1…11 with bit 22 set for PM. Internal hour 00 reads as 12 AM, and internal hour 12 reads as 12 PM. AM/PM flips when the hour passes from 11 to 12. Changing the mode changes only the presentation, not the stored time.
- R5: A time write (selector 0) uses the `time_o` layout. It is accepted only if all of these hold: every digit is BCD, seconds and minutes are below 60, the hour is 00–23 (24-hour mode) or 01–12 (12-hour mode, with bit 22 as PM), and bits 31:23, 15 and 7 are zero.
- R6: A calendar write (selector 1) uses the `cal_o` layout. It is accepted only if all of these hold: every digit is BCD, the century is one of the two covered, the month is 01–12, the day-of-week is 1–7, the date lies from 01 to that month's length under R3 for the written year and century, and bits 31:30 are zero.
- R7: A refused write leaves every register unchanged and sets the sticky entry-error flag.
- R8: An alarm write (selector 2) stores seconds [6:0], minutes [14:8], hour [21:16] with PM [22] (read per the current mode), and date [29:24]. The enables are bit 7 (seconds), bit 15 (minutes), bit 23 (hour) and bit 30 (date). Only enabled fields are range-checked, and bit 31 must be zero. With at least one enable set, the alarm flag sets in the cycle after all enabled fields first equal the running values.
- R9: Control bits [3:1] select the periodic event. The codes are 1 every tick, 2 each minute rollover, 3 each hour rollover, 4 each midnight, 5 at midnight leaving day-of-week 7, and 6 at the end of a month. Codes 0 and 7 turn the event off. A selected event sets the periodic flag on the tick that causes it.
- R10: The alarm, periodic and entry-error flags are sticky. A control write (selector 3) clears them for each 1 in bits 8, 9 and 10 respectively, and a new event in the same cycle wins over the clear. `irq` is the OR of the alarm and periodic flags.
- R11: A tick that arrives in the same cycle as an accepted time or calendar write is discarded, and the written values are kept as written.
- R12: The day-of-week counts 1 to 7 and advances at each midnight, wrapping from 7 to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1hz | input | 1 | One-cycle pulse per second |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 2 | Write target: 0 time, 1 calendar, 2 alarm, 3 control |
| wr_data | input | 32 | Write word |
| time_o | output | 32 | Current time in the selected hour mode |
| cal_o | output | 32 | Current calendar |
| alarm_flag | output | 1 | Sticky alarm flag |
| period_flag | output | 1 | Sticky periodic flag |
| entry_err | output | 1 | Sticky refused-write flag |
| irq | output | 1 | Interrupt request |

## Verification
The bench targets February in 2000 and in 1900, a 30-day month end, and the final day of the span wrapping back to the first century. A wrong leap rule would show up there as a false 29th or a lost day. It writes illegal digits, an impossible 29 February, a 31 April, an out-of-span century and a 12-hour hour of 00, and expects each to be refused without any register moving. It also crosses 11→12 in both halves of the day in 12-hour mode, where a swapped AM/PM toggle or date carry would be visible at once. Finally, it lands a tick on the same cycle as a time write, where a design that let the tick through would read one second ahead.

// File: rtl/rtc_calendar.sv
module rtc_calendar #(
  parameter int FIRST_CENTURY = 19
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_1hz,
  input  logic        wr_en,
  input  logic [1:0]  wr_sel,
  input  logic [31:0] wr_data,
  output logic [31:0] time_o,
  output logic [31:0] cal_o,
  output logic        alarm_flag,
  output logic        period_flag,
  output logic        entry_err,
  output logic        irq
);
  localparam int LAST_CENTURY = FIRST_CENTURY + 1;
  localparam logic [1:0] SEL_TIME = 2'd0, SEL_CAL = 2'd1, SEL_ALM = 2'd2, SEL_CTRL = 2'd3;

  function automatic int b2i(input logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction
  function automatic logic [7:0] i2b(input int v);
    return {4'(v / 10), 4'(v % 10)};
  endfunction
  function automatic logic nib_ok(input logic [7:0] b);
    return (b[7:4] <= 4'd9) && (b[3:0] <= 4'd9);
  endfunction
  function automatic int days_in(input int mm, input int yy, input int cc);
    logic leap;
    leap = (yy % 4 == 0) && (yy != 0 || cc % 4 == 0);
    case (mm)
      2:          return leap ? 29 : 28;
      4, 6, 9, 11: return 30;
      default:    return 31;
    endcase
  endfunction
  function automatic int to24(input int hh, input logic pm, input logic m12);
    if (!m12) return hh;
    if (hh == 12) return pm ? 12 : 0;
    return pm ? hh + 12 : hh;
  endfunction

  logic [7:0] sec, min, hr, date, mon, yr, cen;
  logic [2:0] dow, psel;
  logic [7:0] a_sec, a_min, a_hr, a_date;
  logic [3:0] a_en;
  logic       mode12, mq;

  int s, m, h, d, mo, y, c, dmax;
  assign s = b2i(sec);
  assign m = b2i(min);
  assign h = b2i(hr);
  assign d = b2i(date);
  assign mo = b2i(mon);
  assign y = b2i(yr);
  assign c = b2i(cen);
  assign dmax = days_in(mo, y, c);

  wire [7:0] w_s  = {1'b0, wr_data[6:0]};
  wire [7:0] w_m  = {1'b0, wr_data[14:8]};
  wire [7:0] w_h  = {2'b0, wr_data[21:16]};
  wire [7:0] w_c  = wr_data[7:0];
  wire [7:0] w_y  = wr_data[15:8];
  wire [7:0] w_mo = {3'b0, wr_data[20:16]};
  wire [7:0] w_dt = {2'b0, wr_data[29:24]};
  wire [2:0] w_dw = wr_data[23:21];
  int wh, wdt, wmo, wc;
  assign wh  = b2i(w_h);
  assign wdt = b2i(w_dt);
  assign wmo = b2i(w_mo);
  assign wc  = b2i(w_c);

  wire sec_ok  = nib_ok(w_s) && b2i(w_s) < 60;
  wire min_ok  = nib_ok(w_m) && b2i(w_m) < 60;
  wire hour_ok = nib_ok(w_h) && (mode12 ? (wh >= 1 && wh <= 12) : wh <= 23);
  wire [7:0] w_h24 = i2b(to24(wh, wr_data[22], mode12));

  wire time_ok = (wr_data & 32'hFF80_8080) == 32'd0 && sec_ok && min_ok && hour_ok;
  wire cal_ok  = wr_data[31:30] == 2'b00 && nib_ok(w_c) && nib_ok(w_y) && nib_ok(w_mo)
               && nib_ok(w_dt) && (wc == FIRST_CENTURY || wc == LAST_CENTURY)
               && wmo >= 1 && wmo <= 12 && w_dw != 3'd0
               && wdt >= 1 && wdt <= days_in(wmo, b2i(w_y), wc);
  wire alm_ok  = !wr_data[31] && (!wr_data[7] || sec_ok) && (!wr_data[15] || min_ok)
               && (!wr_data[23] || hour_ok)
               && (!wr_data[30] || (nib_ok(w_dt) && wdt >= 1 && wdt <= 31));

  logic w_ok;
  always_comb
    case (wr_sel)
      SEL_TIME: w_ok = time_ok;
      SEL_CAL:  w_ok = cal_ok;
      SEL_ALM:  w_ok = alm_ok;
      default:  w_ok = 1'b1;
    endcase

  wire accept = wr_en && w_ok;
  wire reject = wr_en && !w_ok;
  wire clr    = wr_en && wr_sel == SEL_CTRL;
  wire adv    = tick_1hz && !(accept && (wr_sel == SEL_TIME || wr_sel == SEL_CAL));

  wire c_s  = s == 59;
  wire c_m  = c_s && m == 59;
  wire c_h  = c_m && h == 23;
  wire c_d  = c_h && d == dmax;
  wire c_mo = c_d && mo == 12;
  wire c_y  = c_mo && y == 99;

  logic p_hit;
  always_comb
    case (psel)
      3'd1:    p_hit = 1'b1;
      3'd2:    p_hit = c_s;
      3'd3:    p_hit = c_m;
      3'd4:    p_hit = c_h;
      3'd5:    p_hit = c_h && dow == 3'd7;
      3'd6:    p_hit = c_d;
      default: p_hit = 1'b0;
    endcase

  wire a_hit = (a_en != 4'd0) && (!a_en[0] || a_sec == sec) && (!a_en[1] || a_min == min)
             && (!a_en[2] || a_hr == hr) && (!a_en[3] || a_date == date);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sec <= 8'h00; min <= 8'h00; hr <= 8'h00;
      date <= 8'h01; mon <= 8'h01; yr <= 8'h00; cen <= i2b(FIRST_CENTURY); dow <= 3'd1;
      a_sec <= 8'h00; a_min <= 8'h00; a_hr <= 8'h00; a_date <= 8'h00; a_en <= 4'd0;
      mode12 <= 1'b0; psel <= 3'd0; mq <= 1'b0;
      alarm_flag <= 1'b0; period_flag <= 1'b0; entry_err <= 1'b0;
    end else begin
      if (adv) begin
        sec <= c_s ? 8'h00 : i2b(s + 1);
        if (c_s) min <= c_m ? 8'h00 : i2b(m + 1);
        if (c_m) hr <= c_h ? 8'h00 : i2b(h + 1);
        if (c_h) begin
          dow  <= (dow == 3'd7) ? 3'd1 : dow + 3'd1;
          date <= c_d ? 8'h01 : i2b(d + 1);
        end
        if (c_d) mon <= c_mo ? 8'h01 : i2b(mo + 1);
        if (c_mo) yr <= c_y ? 8'h00 : i2b(y + 1);
        if (c_y) cen <= (c == LAST_CENTURY) ? i2b(FIRST_CENTURY) : i2b(c + 1);
      end
      if (accept)
        case (wr_sel)
          SEL_TIME: begin sec <= w_s; min <= w_m; hr <= w_h24; end
          SEL_CAL: begin
            cen <= w_c; yr <= w_y; mon <= w_mo; dow <= w_dw; date <= w_dt;
          end
          SEL_ALM: begin
            a_sec <= w_s; a_min <= w_m; a_hr <= w_h24; a_date <= w_dt;
            a_en <= {wr_data[30], wr_data[23], wr_data[15], wr_data[7]};
          end
          default: begin mode12 <= wr_data[0]; psel <= wr_data[3:1]; end
        endcase
      mq          <= a_hit;
      alarm_flag  <= (a_hit && !mq) || (alarm_flag && !(clr && wr_data[8]));
      period_flag <= (adv && p_hit) || (period_flag && !(clr && wr_data[9]));
      entry_err   <= reject || (entry_err && !(clr && wr_data[10]));
    end

  int h12;
  assign h12 = (h == 0) ? 12 : ((h > 12) ? h - 12 : h);
  wire [5:0] h_out = 6'(mode12 ? i2b(h12) : hr);
  assign time_o = {9'd0, mode12 && h >= 12, h_out, 1'b0, min[6:0], 1'b0, sec[6:0]};
  assign cal_o  = {2'b00, date[5:0], dow, mon[4:0], yr, cen};
  assign irq    = alarm_flag | period_flag;

  assert_bcd_time_R1: assert property (@(posedge clk) disable iff (!rst_n)
    sec[3:0] <= 4'd9 && sec < 8'h60 && min[3:0] <= 4'd9 && min < 8'h60
    && hr[3:0] <= 4'd9 && hr < 8'h24);

  assert_date_in_month_R3: assert property (@(posedge clk) disable iff (!rst_n)
    d >= 1 && d <= dmax && mo >= 1 && mo <= 12 && dow != 3'd0);

  assert_reject_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_CAL && !cal_ok && !tick_1hz)
    |=> $stable(date) && $stable(mon) && $stable(yr) && $stable(cen) && $stable(dow));

  assert_reject_flags_R10: assert property (@(posedge clk) disable iff (!rst_n)
    reject |=> entry_err);

  assert_write_beats_tick_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_1hz && wr_en && wr_sel == SEL_TIME && time_ok)
    |=> sec == {1'b0, $past(wr_data[6:0])});
endmodule

// File: tb/tb_rtc_calendar.sv
module tb_rtc_calendar;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, wr_en = 1'b0;
  logic [1:0] wr_sel = 2'd0;
  logic [31:0] wr_data = 32'd0;
  logic [31:0] time_o, cal_o;
  logic alarm_flag, period_flag, entry_err, irq;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rtc_calendar dut (
    .clk(clk), .rst_n(rst_n), .tick_1hz(tick), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .time_o(time_o), .cal_o(cal_o), .alarm_flag(alarm_flag),
    .period_flag(period_flag), .entry_err(entry_err), .irq(irq)
  );

  int ms, mm, mh, mdw, mdt, mmo, my, mc, as_, am_, ah_, ad_, ps;
  bit [3:0] aen;
  bit m12, fa, fp, fi, mq;

  function automatic int dv(input int x);
    if (((x >> 4) & 15) > 9 || (x & 15) > 9) return -1;
    return ((x >> 4) & 15) * 10 + (x & 15);
  endfunction
  function automatic int bcd(input int v);
    return (v / 10) * 16 + v % 10;
  endfunction
  function automatic int mdays(input int mo, input int y, input int c);
    bit lp = (y % 4 == 0) && (y != 0 || c % 4 == 0);
    if (mo == 2) return lp ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction
  function automatic logic [31:0] tw(input int h, input int mi, input int s, input int pm);
    return 32'((pm << 22) | (bcd(h) << 16) | (bcd(mi) << 8) | bcd(s));
  endfunction
  function automatic logic [31:0] cw(input int c, input int y, input int mo, input int dw, input int dt);
    return 32'((bcd(dt) << 24) | (dw << 21) | (bcd(mo) << 16) | (bcd(y) << 8) | bcd(c));
  endfunction
  function automatic logic [31:0] exp_time();
    int h = mh;
    int pm = 0;
    if (m12) begin pm = (mh >= 12) ? 1 : 0; h = (mh % 12 == 0) ? 12 : mh % 12; end
    return tw(h, mm, ms, pm);
  endfunction

  task automatic mreset();
    ms = 0; mm = 0; mh = 0; mdt = 1; mmo = 1; my = 0; mc = 19; mdw = 1;
    aen = 0; as_ = 0; am_ = 0; ah_ = 0; ad_ = 0; ps = 0;
    m12 = 0; fa = 0; fp = 0; fi = 0; mq = 0;
  endtask

  task automatic mstep();
    int dd, s, mi, h, pm, c, y, mo, dw, dt, h24, dm;
    bit ok, hok, wtc, adv, cs, cm, ch, cd, cmo, cy, hit, mt, clr;
    dd = int'(wr_data);
    dm = mdays(mmo, my, mc);
    mt = aen != 0 && (!aen[0] || as_ == ms) && (!aen[1] || am_ == mm)
         && (!aen[2] || ah_ == mh) && (!aen[3] || ad_ == mdt);
    s = dv(dd & 127); mi = dv((dd >> 8) & 127); h = dv((dd >> 16) & 63); pm = (dd >> 22) & 1;
    hok = h >= 0 && (m12 ? (h >= 1 && h <= 12) : h <= 23);
    h24 = !m12 ? h : (h == 12 ? (pm != 0 ? 12 : 0) : (pm != 0 ? h + 12 : h));
    c = dv(dd & 255); y = dv((dd >> 8) & 255); mo = dv((dd >> 16) & 31);
    dw = (dd >> 21) & 7; dt = dv((dd >> 24) & 63);
    ok = 1;
    if (wr_en)
      case (wr_sel)
        2'd0: ok = (wr_data & 32'hFF80_8080) == 0 && s >= 0 && s < 60 && mi >= 0 && mi < 60 && hok;
        2'd1: ok = wr_data[31:30] == 0 && (c == 19 || c == 20) && y >= 0 && mo >= 1 && mo <= 12
                   && dw >= 1 && dt >= 1 && dt <= mdays(mo, y, c);
        2'd2: ok = !wr_data[31] && (!wr_data[7] || (s >= 0 && s < 60))
                   && (!wr_data[15] || (mi >= 0 && mi < 60)) && (!wr_data[23] || hok)
                   && (!wr_data[30] || (dt >= 1 && dt <= 31));
        default: ok = 1;
      endcase
    wtc = wr_en && ok && wr_sel <= 2'd1;
    clr = wr_en && wr_sel == 2'd3;
    adv = tick && !wtc;
    cs = ms == 59; cm = cs && mm == 59; ch = cm && mh == 23; cd = ch && mdt == dm;
    cmo = cd && mmo == 12; cy = cmo && my == 99;
    case (ps)
      1: hit = 1; 2: hit = cs; 3: hit = cm; 4: hit = ch; 5: hit = ch && mdw == 7; 6: hit = cd;
      default: hit = 0;
    endcase
    fa = (mt && !mq) || (fa && !(clr && wr_data[8]));
    mq = mt;
    fp = (adv && hit) || (fp && !(clr && wr_data[9]));
    fi = (wr_en && !ok) || (fi && !(clr && wr_data[10]));
    if (adv) begin
      ms = cs ? 0 : ms + 1;
      if (cs) mm = cm ? 0 : mm + 1;
      if (cm) mh = ch ? 0 : mh + 1;
      if (ch) begin mdw = (mdw == 7) ? 1 : mdw + 1; mdt = cd ? 1 : mdt + 1; end
      if (cd) mmo = cmo ? 1 : mmo + 1;
      if (cmo) my = cy ? 0 : my + 1;
      if (cy) mc = (mc == 20) ? 19 : mc + 1;
    end
    if (wr_en && ok)
      case (wr_sel)
        2'd0: begin ms = s; mm = mi; mh = h24; end
        2'd1: begin mc = c; my = y; mmo = mo; mdw = dw; mdt = dt; end
        2'd2: begin
          aen = {wr_data[30], wr_data[23], wr_data[15], wr_data[7]};
          as_ = s; am_ = mi; ah_ = h24; ad_ = dt;
        end
        default: begin m12 = wr_data[0]; ps = (dd >> 1) & 7; end
      endcase
  endtask

  always @(posedge clk)
    if (!rst_n) mreset();
    else mstep();

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  always @(negedge clk)
    if (rst_n && !done) begin
      chk(time_o, exp_time(), "R2 time_o vs model");
      chk(cal_o, cw(mc, my, mmo, mdw, mdt), "R3 cal_o vs model");
      chk({28'd0, alarm_flag, period_flag, entry_err, irq}, {28'd0, fa, fp, fi, fa | fp},
          "R10 flags vs model");
    end

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask
  task automatic tk(input int n);
    repeat (n) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  initial begin
    logic [31:0] snap;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk(time_o, 32'h0, "R1 reset time");
    chk(cal_o, 32'h0121_0019, "R1 reset calendar");
    chk({29'd0, alarm_flag, period_flag, entry_err}, 32'd0, "R1 reset flags");
    tk(5);
    chk(time_o, tw(0, 0, 5, 0), "R2 five ticks");
    wr(2'd0, tw(23, 59, 58, 0)); wr(2'd1, cw(19, 99, 12, 5, 31)); tk(3);
    chk(cal_o, cw(20, 0, 1, 6, 1), "R3 new year into next century");
    chk(time_o, tw(0, 0, 1, 0), "R2 midnight carry");
    wr(2'd1, cw(20, 0, 2, 1, 28)); wr(2'd0, tw(23, 59, 59, 0)); tk(1);
    chk(cal_o, cw(20, 0, 2, 2, 29), "R3 leap day in year 2000");
    wr(2'd0, tw(23, 59, 59, 0)); tk(1);
    chk(cal_o, cw(20, 0, 3, 3, 1), "R3 after leap day");
    wr(2'd1, cw(19, 0, 2, 3, 28)); wr(2'd0, tw(23, 59, 59, 0)); tk(1);
    chk(cal_o, cw(19, 0, 3, 4, 1), "R3 year 1900 not leap");
    wr(2'd1, cw(20, 99, 12, 4, 31)); wr(2'd0, tw(23, 59, 59, 0)); tk(1);
    chk(cal_o, cw(19, 0, 1, 5, 1), "R3 span wraps to first century");
    wr(2'd1, cw(20, 23, 4, 7, 30)); wr(2'd0, tw(23, 59, 59, 0)); tk(1);
    chk(cal_o, cw(20, 23, 5, 1, 1), "R12 day-of-week 7 to 1 and 30-day month");
    snap = cal_o;
    wr(2'd1, cw(19, 99, 2, 1, 29));
    chk(cal_o, snap, "R7 29 Feb 1999 keeps calendar");
    chk({31'd0, entry_err}, 32'd1, "R6 29 Feb 1999 refused");
    wr(2'd1, cw(20, 1, 4, 1, 31));
    wr(2'd1, cw(21, 1, 1, 1, 1));
    wr(2'd1, 32'h0121_0A20);
    chk(cal_o, snap, "R6 bad month end, century, digit refused");
    wr(2'd3, 32'h0000_0700);
    chk({31'd0, entry_err}, 32'd0, "R10 entry error cleared by control write");
    snap = time_o;
    wr(2'd0, tw(24, 0, 0, 0)); wr(2'd0, 32'h0000_005A); wr(2'd0, tw(0, 60, 0, 0));
    wr(2'd0, 32'h8000_0000);
    chk(time_o, snap, "R5 illegal time writes refused");
    chk({31'd0, entry_err}, 32'd1, "R7 refused time sets entry error");
    wr(2'd3, 32'h0000_0401);
    wr(2'd0, tw(11, 59, 59, 1)); tk(1);
    chk(time_o, tw(12, 0, 0, 0), "R4 11 PM to 12 AM");
    wr(2'd0, tw(11, 59, 59, 0)); tk(1);
    chk(time_o, tw(12, 0, 0, 1), "R4 11 AM to 12 PM");
    wr(2'd0, tw(12, 59, 59, 1)); tk(1);
    chk(time_o, tw(1, 0, 0, 1), "R4 12 PM to 1 PM");
    wr(2'd0, tw(0, 0, 0, 0));
    chk({31'd0, entry_err}, 32'd1, "R5 hour 00 refused in 12-hour mode");
    wr(2'd3, 32'h0000_0400);
    chk(time_o, tw(13, 0, 0, 0), "R4 mode switch keeps stored time");
    wr(2'd0, tw(10, 0, 0, 0)); wr(2'd2, 32'h0000_0083);
    chk({31'd0, alarm_flag}, 32'd0, "R8 alarm idle before match");
    tk(5);
    chk({31'd0, alarm_flag}, 32'd1, "R8 alarm on seconds match");
    chk({31'd0, irq}, 32'd1, "R10 irq follows alarm");
    wr(2'd3, 32'h0000_0100);
    wr(2'd2, 32'h0090_8100); tk(62);
    chk({31'd0, alarm_flag}, 32'd1, "R8 alarm on hour and minute match");
    wr(2'd2, 32'h0000_00F5);
    chk({31'd0, entry_err}, 32'd1, "R8 enabled illegal alarm field refused");
    wr(2'd2, 32'h0000_007F);
    wr(2'd3, 32'h0000_0702); tk(2);
    chk({31'd0, period_flag}, 32'd1, "R9 every-tick event");
    wr(2'd3, 32'h0000_0204); wr(2'd0, tw(10, 0, 58, 0)); tk(1);
    chk({31'd0, period_flag}, 32'd0, "R9 no minute event mid-minute");
    tk(1);
    chk({31'd0, period_flag}, 32'd1, "R9 minute event");
    wr(2'd3, 32'h0000_020A); wr(2'd1, cw(20, 24, 6, 7, 30)); wr(2'd0, tw(23, 59, 59, 0)); tk(1);
    chk({31'd0, period_flag}, 32'd1, "R9 week event");
    wr(2'd3, 32'h0000_020C); wr(2'd0, tw(23, 59, 59, 0)); tk(1);
    chk({31'd0, period_flag}, 32'd0, "R9 no month event on 1 July");
    wr(2'd1, cw(20, 24, 7, 3, 31)); wr(2'd0, tw(23, 59, 59, 0)); tk(1);
    chk({31'd0, period_flag}, 32'd1, "R9 month event");
    @(negedge clk); tick = 1'b1; wr_en = 1'b1; wr_sel = 2'd0; wr_data = tw(5, 5, 5, 0);
    @(negedge clk); tick = 1'b0; wr_en = 1'b0;
    chk(time_o, tw(5, 5, 5, 0), "R11 tick discarded during time write");
    @(negedge clk); tick = 1'b1; wr_en = 1'b1; wr_sel = 2'd0; wr_data = tw(25, 0, 0, 0);
    @(negedge clk); tick = 1'b0; wr_en = 1'b0;
    chk(time_o, tw(5, 5, 6, 0), "R11 tick kept during refused write");
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule